// File: doc/BRIEF.md
# Floating-Point Immediate Half-Word Load Unit

This execution-unit datapath builds a single-precision constant inside a 64-bit floating-point register from two 16-bit immediates. An "upper" operation takes its immediate as the high half of a single-precision pattern, with the low half zero. It widens that value exactly to double precision and writes it to the target register. A "lower" operation reads the register and narrows the value to single precision. It then puts the immediate into the low half, widens the result again and writes it back to the same register.

Each 32-bit instruction word carries the immediate in three separate fields, which the unit gathers back together. The result, the target index and a write enable come out one cycle after the instruction is presented. A register file outside the block takes that write. A lower operation can follow an upper operation to the same register in the next valid cycle. In that case the unit forms the full 32-bit pattern from both immediates and does not read the register, because the register would still hold the stale value. No status or flag output exists, so neither operation can change floating-point flags.

Top module: `fhl_unit`

## Requirements
- R1: The instruction word is split MSB-first into opcode [31:26], target [25:21], field A [20:16], field B [15:6], sub-opcode [5:1] and field C [0]. The immediate is B concatenated with A and then C, with B in the most significant position. A write goes to `wr_idx` = target.
- R2: Opcode 22 with sub-opcode 3 selects the upper operation, and opcode 22 with sub-opcode 4 selects the lower operation. Any other word produces no write (`wr_en` low in the next cycle).
- R3: An upper operation writes the exact double-precision value of the single-precision pattern {imm, 16'h0000}. For example, 0x7F80 gives 0x7FF0000000000000, 0xFF80 gives 0xFFF0000000000000 and 0x3FFF gives 0x3FFFE00000000000.
- R4: A lower operation narrows `rs_data` to single precision, replaces single-precision bits [15:0] with the immediate and writes the exact double-precision value of the result.
- R5: Widening keeps the sign. Zero stays zero, infinity stays infinity, and a NaN keeps its fraction left-aligned in the wider fraction. Written results always have bits [28:0] equal to zero.
- R6: A single-precision denormal widens to a normalized double: the leading fraction bit is removed and the exponent becomes 874 plus that bit's position.
- R7: Narrowing takes the sign and the top 23 fraction bits without rounding. A double exponent of 0 maps to 0, 2047 maps to 255, and any other value e maps to the low 8 bits of e − 896.
- R8: When a lower operation directly follows an upper operation in the next cycle, both valid and naming the same target, the lower result uses the earlier upper immediate as its high half and ignores `rs_data`. Upper 0x3F80 followed by lower 0x8000 writes 0x3FF0100000000000.
- R9: A lower operation that follows a bubble cycle, or an upper operation to a different target, takes its high half from `rs_data`.
- R10: `wr_en`, `wr_idx` and `wr_data` are registered one cycle after the accepted instruction, and `wr_en` is low after a cycle with `in_valid` low.
- R11: While `rst_n` is low, `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| rs_data | input | 64 | Current contents of the target register |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Register index to write |
| wr_data | output | 64 | Double-precision value to write |

## Verification
On every cycle the assertions check four things. Each write comes from a valid instruction and goes to the index taken from that word. Unknown opcodes never write. Every written value has its low 29 bits at zero, and an upper immediate with an all-ones exponent always writes an infinity or NaN with the same sign. The exact numeric results can only be shown by the bench scenarios, which compare against reference functions. This covers denormal normalisation, NaN payload placement, the narrowing round trip, and the choice between the fused immediate and the register contents. Each scenario depends on a specific ordering of back-to-back cycles, bubbles and target registers.

// File: rtl/fhl_pkg.sv
// Package: shared types and format constants for the half-word load unit.
// Assumes IEEE-754 binary32 and binary64 layouts.
package fhl_pkg;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int IMM_W     = 16;
    localparam int REG_W     = 5;
    localparam int FRAC_PAD  = DP_FRAC_W - SP_FRAC_W;
    localparam int BIAS_DIFF = 896;
    // exponent given to a denormal whose leading one sits at bit 0
    localparam int DENORM_BASE = BIAS_DIFF - SP_FRAC_W + 1;

    // instruction word, most significant field first
    typedef struct packed {
        logic [5:0]  major;
        logic [4:0]  tgt;
        logic [4:0]  fa;
        logic [9:0]  fb;
        logic [4:0]  sub;
        logic        fc;
    } dx_word_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_HI   = 2'd1,
        OP_LO   = 2'd2
    } op_kind_t;
endpackage

// File: rtl/fhl_decode.sv
// Decoder: picks the operation kind, the target register and the
// reassembled 16-bit immediate out of one instruction word.
// Assumes the opcode values come in as parameters.
module fhl_decode
    import fhl_pkg::*;
#(
    parameter logic [5:0] MAJOR_OP = 6'd22,
    parameter logic [4:0] XO_HI    = 5'd3,
    parameter logic [4:0] XO_LO    = 5'd4
) (
    input  logic [31:0]      instr,
    output op_kind_t         kind,
    output logic [REG_W-1:0] tgt,
    output logic [IMM_W-1:0] imm
);
    dx_word_t w;
    assign w   = dx_word_t'(instr);
    assign tgt = w.tgt;
    assign imm = {w.fb, w.fa, w.fc};

    // classify the opcode pair
    always_comb begin
        kind = OP_NONE;
        if (w.major == MAJOR_OP) begin
            if (w.sub == XO_HI)      kind = OP_HI;
            else if (w.sub == XO_LO) kind = OP_LO;
        end
    end
endmodule

// File: rtl/fhl_narrow.sv
// Narrower: double to single by truncation with the exponent rebiased.
// Assumes in-range inputs; no rounding and no overflow handling.
module fhl_narrow
    import fhl_pkg::*;
(
    input  logic [63:0] dp,
    output logic [31:0] sp
);
    logic [DP_EXP_W-1:0] e;
    logic [SP_EXP_W-1:0] se;
    logic                unused_tail;
    assign e           = dp[62:52];
    assign unused_tail = ^dp[FRAC_PAD-1:0];

    // map exponent classes
    always_comb begin
        if (e == '0)       se = '0;
        else if (&e)       se = '1;
        else               se = SP_EXP_W'(e - DP_EXP_W'(BIAS_DIFF));
    end

    assign sp = {dp[63], se, dp[51:FRAC_PAD]};
endmodule

// File: rtl/fhl_widen.sv
// Widener: exact single to double conversion. Zeros, infinities and NaNs
// keep their class and sign, and denormals are normalized.
// Assumes nothing about the input pattern.
module fhl_widen
    import fhl_pkg::*;
(
    input  logic [31:0] sp,
    output logic [63:0] dp
);
    logic [SP_EXP_W-1:0]  e;
    logic [SP_FRAC_W-1:0] f;
    logic [4:0]           lead;
    logic [SP_FRAC_W-1:0] fn;
    assign e = sp[30:23];
    assign f = sp[22:0];

    // locate the highest set fraction bit
    always_comb begin
        lead = '0;
        for (int i = 0; i < SP_FRAC_W; i++) begin
            if (f[i]) lead = 5'(i);
        end
    end

    assign fn = f << (5'(SP_FRAC_W) - lead);

    // assemble the double by input class
    always_comb begin
        if (e == '0 && f == '0)
            dp = {sp[31], 63'd0};
        else if (e == '0)
            dp = {sp[31], DP_EXP_W'(DENORM_BASE) + DP_EXP_W'(lead), fn, {FRAC_PAD{1'b0}}};
        else if (&e)
            dp = {sp[31], {DP_EXP_W{1'b1}}, f, {FRAC_PAD{1'b0}}};
        else
            dp = {sp[31], DP_EXP_W'(e) + DP_EXP_W'(BIAS_DIFF), f, {FRAC_PAD{1'b0}}};
    end
endmodule

// File: rtl/fhl_unit.sv
// Top: immediate half-word load unit. Decodes the word, builds the
// single-precision pattern (from the immediate and either the register or
// a just-issued upper immediate), widens it and registers the write.
// Assumes the register file applies wr_* one cycle after the instruction.
module fhl_unit
    import fhl_pkg::*;
#(
    parameter bit         FUSE_EN  = 1'b1,
    parameter logic [5:0] MAJOR_OP = 6'd22,
    parameter logic [4:0] XO_HI    = 5'd3,
    parameter logic [4:0] XO_LO    = 5'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [63:0] rs_data,
    output logic        wr_en,
    output logic [4:0]  wr_idx,
    output logic [63:0] wr_data
);
    op_kind_t         kind;
    logic [REG_W-1:0] tgt;
    logic [IMM_W-1:0] imm;
    logic [31:0]      rs_sp;
    logic [31:0]      sp_mod;
    logic [63:0]      dp_res;
    logic             fuse_hit;
    logic             pend_hi_q;
    logic [REG_W-1:0] pend_tgt_q;
    logic [IMM_W-1:0] pend_imm_q;
    logic             unused_rs_lo;

    fhl_decode #(.MAJOR_OP(MAJOR_OP), .XO_HI(XO_HI), .XO_LO(XO_LO)) u_dec (
        .instr(instr), .kind(kind), .tgt(tgt), .imm(imm)
    );

    fhl_narrow u_nar (.dp(rs_data), .sp(rs_sp));
    assign unused_rs_lo = ^rs_sp[IMM_W-1:0];

    generate
        if (FUSE_EN) begin : g_fuse
            // remember the upper op issued in the previous cycle
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_hi_q  <= 1'b0;
                    pend_tgt_q <= '0;
                    pend_imm_q <= '0;
                end else begin
                    pend_hi_q  <= in_valid && (kind == OP_HI);
                    pend_tgt_q <= tgt;
                    pend_imm_q <= imm;
                end
            end
        end else begin : g_nofuse
            assign pend_hi_q  = 1'b0;
            assign pend_tgt_q = '0;
            assign pend_imm_q = '0;
        end
    endgenerate

    assign fuse_hit = in_valid && (kind == OP_LO) && pend_hi_q && (pend_tgt_q == tgt);

    // choose the high half and place the immediate
    always_comb begin
        if (kind == OP_HI)
            sp_mod = {imm, {IMM_W{1'b0}}};
        else if (fuse_hit)
            sp_mod = {pend_imm_q, imm};
        else
            sp_mod = {rs_sp[31:IMM_W], imm};
    end

    fhl_widen u_wid (.sp(sp_mod), .dp(dp_res));

    // register the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= in_valid && (kind != OP_NONE);
            if (in_valid && (kind != OP_NONE)) begin
                wr_idx  <= tgt;
                wr_data <= dp_res;
            end
        end
    end
endmodule

// File: rtl/fhl_unit_chk.sv
// Checker: cycle-level properties of the write port, attached by bind.
// Assumes the same opcode parameters as the unit it watches.
module fhl_unit_chk #(
    parameter logic [5:0] MAJOR_OP = 6'd22,
    parameter logic [4:0] XO_HI    = 5'd3,
    parameter logic [4:0] XO_LO    = 5'd4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic [63:0] wr_data
);
    logic is_hi, is_lo, unused_bits;
    assign is_hi = (instr[31:26] == MAJOR_OP) && (instr[5:1] == XO_HI);
    assign is_lo = (instr[31:26] == MAJOR_OP) && (instr[5:1] == XO_LO);
    assign unused_bits = ^{instr[20:16], instr[6], instr[0]};

    AST_WE_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid)); // R10
    AST_IDX_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx == $past(instr[25:21])); // R1
    AST_BAD_OP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_hi && !is_lo) |=> !wr_en); // R2
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_data[28:0] == 29'd0); // R5
    AST_HI_INF_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_hi && instr[14:7] == 8'hFF) |=>
        (wr_data[62:52] == 11'h7FF && wr_data[63] == $past(instr[15]))); // R5
endmodule

bind fhl_unit fhl_unit_chk #(.MAJOR_OP(MAJOR_OP), .XO_HI(XO_HI), .XO_LO(XO_LO)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/fhl_unit_tb.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against reference functions written from the requirements.
module fhl_unit_tb;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rs_data = '0;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench-side view of the previous accepted cycle
    bit         m_hi = 1'b0;
    logic [4:0] m_tgt = '0;
    logic [15:0] m_imm = '0;

    fhl_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs_data(rs_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [31:0] mk(input logic [4:0] xo, input logic [4:0] t,
                                       input logic [15:0] im, input logic [5:0] maj = 6'd22);
        return {maj, t, im[5:1], im[15:6], xo, im[0]};
    endfunction

    function automatic logic [63:0] ref_widen(input logic [31:0] s);
        logic [7:0]  e;
        logic [23:0] f;
        int          ex;
        e = s[30:23];
        f = {1'b0, s[22:0]};
        if (e == 0 && f == 0) return {s[31], 63'd0};
        if (e == 8'hFF) return {s[31], 11'h7FF, s[22:0], 29'd0};
        if (e != 0) return {s[31], 11'(int'(e) + 896), s[22:0], 29'd0};
        ex = 897;
        while (!f[23]) begin
            f = f << 1;
            ex = ex - 1;
        end
        return {s[31], 11'(ex), f[22:0], 29'd0};
    endfunction

    function automatic logic [31:0] ref_narrow(input logic [63:0] d);
        int e;
        logic [7:0] se;
        e = int'(d[62:52]);
        if (e == 0) se = 8'd0;
        else if (e == 2047) se = 8'hFF;
        else se = 8'(e - 896);
        return {d[63], se, d[51:29]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle, then compare the registered outputs
    task automatic step(input bit v, input logic [31:0] w, input logic [63:0] rs, input string req);
        logic [5:0]  maj;
        logic [4:0]  xo, t;
        logic [15:0] im;
        bit          hi, lo, exp_we;
        logic [63:0] exp_d;
        maj = w[31:26]; t = w[25:21]; xo = w[5:1];
        im  = {w[15:6], w[20:16], w[0]};
        hi  = v && maj == 6'd22 && xo == 5'd3;
        lo  = v && maj == 6'd22 && xo == 5'd4;
        exp_we = hi || lo;
        if (hi) exp_d = ref_widen({im, 16'h0});
        else if (lo && m_hi && m_tgt == t) exp_d = ref_widen({m_imm, im});
        else exp_d = ref_widen({ref_narrow(rs)[31:16], im});
        @(negedge clk);
        in_valid = v; instr = w; rs_data = rs;
        @(posedge clk);
        #1;
        check(wr_en == exp_we, {req, " wr_en"}, 64'(wr_en), 64'(exp_we));
        if (exp_we) begin
            check(wr_idx == t, {req, " R1 idx"}, 64'(wr_idx), 64'(t));
            check(wr_data == exp_d, {req, " data"}, wr_data, exp_d);
        end
        m_hi = hi; m_tgt = t; m_imm = im;
    endtask

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #1;
        check(wr_en == 1'b0, "R11 reset wr_en", 64'(wr_en), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 stated examples
        step(1, mk(5'd3, 5'd4, 16'h7F80), 64'h0, "R3 +inf");
        check(wr_data == 64'h7FF0000000000000, "R3 +inf literal", wr_data, 64'h7FF0000000000000);
        step(1, mk(5'd3, 5'd4, 16'hFF80), 64'h0, "R3 -inf");
        step(1, mk(5'd3, 5'd4, 16'h3FFF), 64'h0, "R3 1.9921875");
        check(wr_data == 64'h3FFFE00000000000, "R3 1.99 literal", wr_data, 64'h3FFFE00000000000);
        // R5 zeros and NaN, R6 denormals
        step(1, mk(5'd3, 5'd1, 16'h0000), 64'h0, "R5 +zero");
        step(1, mk(5'd3, 5'd1, 16'h8000), 64'h0, "R5 -zero");
        step(1, mk(5'd3, 5'd1, 16'h7FC1), 64'h0, "R5 nan payload");
        step(1, mk(5'd3, 5'd2, 16'h0040), 64'h0, "R6 denorm hi");
        check(wr_data == 64'h3800000000000000, "R6 2^-127 literal", wr_data, 64'h3800000000000000);
        step(1, mk(5'd3, 5'd2, 16'h8001), 64'h0, "R6 neg denorm hi");
        // R8 fused pair ignores garbage rs_data
        step(1, mk(5'd3, 5'd7, 16'h3F80), 64'hDEAD_BEEF_0123_4567, "R8 pair hi");
        step(1, mk(5'd4, 5'd7, 16'h8000), 64'hDEAD_BEEF_0123_4567, "R8 pair lo");
        check(wr_data == 64'h3FF0100000000000, "R8 fused literal", wr_data, 64'h3FF0100000000000);
        // R9 bubble breaks fusion, R10 no write on bubble
        step(1, mk(5'd3, 5'd7, 16'h4000), 64'h0, "R9 hi");
        step(0, mk(5'd4, 5'd7, 16'h1111), 64'h0, "R10 bubble");
        step(1, mk(5'd4, 5'd7, 16'h8000), 64'h3FF0000000000000, "R9 after bubble");
        check(wr_data == 64'h3FF0100000000000, "R4 lo literal", wr_data, 64'h3FF0100000000000);
        // R9 different target
        step(1, mk(5'd3, 5'd3, 16'h4000), 64'h0, "R9 hi other");
        step(1, mk(5'd4, 5'd5, 16'h0001), 64'hC000000000000000, "R9 other tgt");
        // R7 narrowing classes
        step(1, mk(5'd4, 5'd6, 16'h0001), 64'h0000_0000_0000_0000, "R7 exp0 to denorm R6");
        check(wr_data == 64'h36A0000000000000, "R6 lo denorm literal", wr_data, 64'h36A0000000000000);
        step(1, mk(5'd4, 5'd6, 16'h1234), 64'h7FF8000000000000, "R7 nan keep");
        step(1, mk(5'd4, 5'd6, 16'hABCD), 64'h4059_0000_FFFF_FFFF, "R7 truncate");
        // R2 bad opcodes
        step(1, mk(5'd3, 5'd2, 16'h3F80, 6'd23), 64'h0, "R2 bad major");
        step(1, mk(5'd5, 5'd2, 16'h3F80), 64'h0, "R2 bad sub");

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int sel;
            logic [31:0] w;
            logic [63:0] rs;
            sel = int'($urandom % 16);
            rs = (sel % 2 == 0) ? ref_widen($urandom) : {$urandom, $urandom};
            if (sel == 0)
                step(0, $urandom, rs, "R10 rnd bubble");
            else if (sel == 1)
                step(1, mk(5'($urandom % 3) + 5'd5, 5'($urandom), 16'($urandom)), rs, "R2 rnd bad");
            else if (sel < 9)
                step(1, mk(5'd3, 5'($urandom % 3), 16'($urandom)), rs, "R3 rnd hi");
            else
                step(1, mk(5'd4, 5'($urandom % 3), 16'($urandom)), rs, "R4 rnd lo");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule